// File: doc/BRIEF.md
# Compressed-Mode Instruction Parcel Sequencer

This block sits at the front of an instruction decoder that accepts a mixed stream of 32-bit standard instructions and 10-bit and 16-bit compressed instructions. Parcels of 16 bits arrive with a valid/ready handshake. For each parcel, or pair of parcels, the sequencer decides the instruction's format class and extracts the compressed major and minor opcode. It flags the all-zero illegal pattern, the nop patterns and the reserved pattern. It also tracks which encoding mode applies to the following instruction.

Mode changes are carried inside each instruction. In standard mode, a parcel whose top five bits are zero is a single-parcel 10-bit instruction, and its last bit chooses the next mode. In 16-bit mode, the first and last bits of every parcel (N and M) choose among four outcomes: stay, leave for good, take exactly one standard instruction and come back, or mark an immediate-form instruction. A flush input with a target mode lets a branch redirect discard a half-assembled 32-bit word and set the mode.

Bits are numbered 0 (most significant, vector bit 15) to 15 (least significant, vector bit 0) in the requirements below.

Top module: `cparcel_seq`

## Requirements
- R1: After synchronous reset, out_mode is 0 (standard) and out_valid is 0. The mode codes are 0 standard, 1 sixteen-bit, 2 one-shot standard.
- R2: In standard mode, a parcel with bits 0-4 (vector bits 15:11) not all zero starts a 32-bit instruction and produces no output. The next accepted parcel completes it. Then out_class is 0, out_insn is {first, second}, and out_major/out_minor are 0. Idle cycles between the halves are allowed.
- R3: In standard or one-shot mode with no half held, a parcel with bits 0-4 all zero is a 10-bit instruction: out_class 1, out_major = bits 5-7 (vector 10:8), out_minor = bit 8 (vector 7), out_insn = {16'h0, parcel}. The next mode is standard if M (bit 15, vector 0) is 0, and sixteen-bit if it is 1.
- R4: In sixteen-bit mode, for an opcode other than 001.1, N (bit 0, vector 15) and M select the outcome. N,M = 0,1 gives class 2 and stays in sixteen-bit mode. N,M = 0,0 gives class 2 and moves to standard mode. N,M = 1,0 gives class 2 and moves to one-shot mode.
- R5: In sixteen-bit mode, N,M = 1,1 with an opcode other than 001.1 gives out_class 3 (immediate form) and stays in sixteen-bit mode.
- R6: In sixteen-bit mode, major 001 with minor 1 gives class 2 whatever N is. M alone selects the next mode: 1 sixteen-bit, 0 standard.
- R7: In one-shot mode, completing a 32-bit instruction returns the mode to sixteen-bit. A 10-bit instruction in one-shot mode sets the mode from its M, as in R3.
- R8: An all-zero parcel in either compressed form asserts out_illegal.
- R9: The parcel 16'h0001 is a nop in both compressed forms. In sixteen-bit mode, 16'h8000 is also a nop and moves to one-shot mode.
- R10: In sixteen-bit mode, a parcel with bit 0 set, bits 1-4 nonzero and bits 5-15 zero asserts out_resv. out_resv is never set outside sixteen-bit mode.
- R11: While flush is high, in_ready is 0 and in_valid is ignored. On the next cycle out_valid is 0, any held first half is discarded, and out_mode becomes 1 if flush_mode is 1, or 0 if it is 0.
- R12: Results are registered. Outputs for a parcel accepted at a clock edge appear after that edge, together with the updated out_mode. out_valid is 0 after cycles that complete no instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Parcel present |
| in_data | input | 16 | Parcel, bit 0 of the numbering at vector bit 15 |
| in_ready | output | 1 | Parcel accepted when high with in_valid |
| flush | input | 1 | Redirect: drop held half and set mode |
| flush_mode | input | 1 | Mode after flush: 1 sixteen-bit, 0 standard |
| out_valid | output | 1 | A classified instruction is presented |
| out_class | output | 2 | 0 std32, 1 c10, 2 c16, 3 c16 immediate |
| out_major | output | 3 | Compressed major opcode |
| out_minor | output | 1 | Compressed minor opcode |
| out_illegal | output | 1 | All-zero compressed parcel |
| out_nop | output | 1 | Nop pattern |
| out_resv | output | 1 | Reserved sixteen-bit pattern |
| out_insn | output | 32 | Instruction bits, compressed ones zero-extended |
| out_mode | output | 2 | Mode for the next instruction |

## Verification
Two functions can fall in the same cycle. The one-shot return to sixteen-bit mode happens as a 32-bit word completes, and a flush can land on the cycle where that word's second half is offered. The bench provokes this by entering one-shot mode, sending a first half, and then raising flush while a second half is valid. It checks that nothing is emitted, that the flush target wins over the pending return, and that the next parcel decodes under the flushed mode. A behavioural model compares every output on every cycle, using a directed sequence and then a pseudo-random stream with occasional flushes.

// File: rtl/cps_pkg.sv
package cps_pkg;

    localparam int PARCEL_W = 16;
    localparam int INSN_W   = 2 * PARCEL_W;
    localparam int MAJ_W    = 3;
    localparam int PFX_W    = 5;

    typedef enum logic [1:0] {
        MD_STD = 2'd0,
        MD_C16 = 2'd1,
        MD_ONE = 2'd2
    } cmode_e;

    typedef enum logic [1:0] {
        FC_STD32  = 2'd0,
        FC_C10    = 2'd1,
        FC_C16    = 2'd2,
        FC_C16IMM = 2'd3
    } fclass_e;

    typedef struct packed {
        logic [MAJ_W-1:0] major;
        logic             minor;
        logic             nbit;
        logic             mbit;
        logic             is_c10;
        logic             is_sub;
        logic             all0;
        logic             nop_m;
        logic             nop_n;
        logic             resv;
    } pfields_t;

    // bit k counted from the most significant end
    function automatic logic msb_bit(input logic [PARCEL_W-1:0] p, input int k);
        return p[PARCEL_W-1-k];
    endfunction

endpackage

// File: rtl/cps_field_dec.sv
module cps_field_dec
    import cps_pkg::*;
(
    input  logic [PARCEL_W-1:0] parcel,
    output pfields_t            f
);
    localparam int MAJ_LO = PARCEL_W - 1 - 7;
    localparam int MIN_B  = 8;
    localparam logic [PARCEL_W-1:0] NOP_M = PARCEL_W'(1);
    localparam logic [PARCEL_W-1:0] NOP_N = NOP_M << (PARCEL_W - 1);

    always_comb begin
        f.major  = parcel[MAJ_LO +: MAJ_W];
        f.minor  = msb_bit(parcel, MIN_B);
        f.nbit   = msb_bit(parcel, 0);
        f.mbit   = msb_bit(parcel, PARCEL_W - 1);
        f.is_c10 = (parcel[PARCEL_W-1 -: PFX_W] == '0);
        f.is_sub = (f.major == MAJ_W'(1)) && f.minor;
        f.all0   = (parcel == '0);
        f.nop_m  = (parcel == NOP_M);
        f.nop_n  = (parcel == NOP_N);
        f.resv   = f.nbit && (parcel[PARCEL_W-2 -: PFX_W-1] != '0)
                   && (parcel[PARCEL_W-PFX_W-1:0] == '0);
    end
endmodule

// File: rtl/cps_mode_next.sv
module cps_mode_next
    import cps_pkg::*;
(
    input  cmode_e   cur,
    input  pfields_t f,
    input  logic     pend,
    output logic     emit,
    output fclass_e  cls,
    output cmode_e   nxt,
    output logic     load_hi,
    output logic     done_pair
);
    always_comb begin
        emit      = 1'b0;
        load_hi   = 1'b0;
        done_pair = 1'b0;
        cls       = FC_C16;
        nxt       = cur;
        if (cur == MD_C16) begin
            emit = 1'b1;
            if (f.is_sub) begin
                nxt = f.mbit ? MD_C16 : MD_STD;
            end else begin
                unique case ({f.nbit, f.mbit})
                    2'b01: nxt = MD_C16;
                    2'b00: nxt = MD_STD;
                    2'b10: nxt = MD_ONE;
                    default: begin
                        cls = FC_C16IMM;
                        nxt = MD_C16;
                    end
                endcase
            end
        end else if (pend) begin
            emit      = 1'b1;
            done_pair = 1'b1;
            cls       = FC_STD32;
            nxt       = (cur == MD_ONE) ? MD_C16 : MD_STD;
        end else if (f.is_c10) begin
            emit = 1'b1;
            cls  = FC_C10;
            nxt  = f.mbit ? MD_C16 : MD_STD;
        end else begin
            load_hi = 1'b1;
        end
    end
endmodule

// File: rtl/cps_pair_asm.sv
module cps_pair_asm
    import cps_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                load,
    input  logic [PARCEL_W-1:0] din,
    output logic [PARCEL_W-1:0] hi,
    output logic                pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            hi   <= '0;
        end else if (clr) begin
            pend <= 1'b0;
        end else if (load) begin
            pend <= 1'b1;
            hi   <= din;
        end
    end

    // R11: a clear always wins over a load in the same cycle
    p_clear_drops_half_r11: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pend);
endmodule

// File: rtl/cparcel_seq.sv
module cparcel_seq
    import cps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [PARCEL_W-1:0]  in_data,
    output logic                 in_ready,
    input  logic                 flush,
    input  logic                 flush_mode,
    output logic                 out_valid,
    output logic [1:0]           out_class,
    output logic [MAJ_W-1:0]     out_major,
    output logic                 out_minor,
    output logic                 out_illegal,
    output logic                 out_nop,
    output logic                 out_resv,
    output logic [INSN_W-1:0]    out_insn,
    output logic [1:0]           out_mode
);
    cmode_e              mode_q;
    pfields_t            fld;
    logic                pend;
    logic [PARCEL_W-1:0] hi;
    logic                emit, load_hi, done_pair, accept;
    fclass_e             cls;
    cmode_e              mode_nx;

    assign in_ready = ~flush;
    assign accept   = in_valid & ~flush;
    assign out_mode = mode_q;

    cps_field_dec u_dec (
        .parcel (in_data),
        .f      (fld)
    );

    cps_mode_next u_next (
        .cur       (mode_q),
        .f         (fld),
        .pend      (pend),
        .emit      (emit),
        .cls       (cls),
        .nxt       (mode_nx),
        .load_hi   (load_hi),
        .done_pair (done_pair)
    );

    cps_pair_asm u_pair (
        .clk  (clk),
        .rst  (rst),
        .clr  (flush | (accept & done_pair)),
        .load (accept & load_hi),
        .din  (in_data),
        .hi   (hi),
        .pend (pend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q      <= MD_STD;
            out_valid   <= 1'b0;
            out_class   <= '0;
            out_major   <= '0;
            out_minor   <= 1'b0;
            out_illegal <= 1'b0;
            out_nop     <= 1'b0;
            out_resv    <= 1'b0;
            out_insn    <= '0;
        end else if (flush) begin
            mode_q    <= flush_mode ? MD_C16 : MD_STD;
            out_valid <= 1'b0;
        end else begin
            out_valid <= accept & emit;
            if (accept) mode_q <= mode_nx;
            if (accept & emit) begin
                out_class <= cls;
                if (cls == FC_STD32) begin
                    out_major   <= '0;
                    out_minor   <= 1'b0;
                    out_illegal <= 1'b0;
                    out_nop     <= 1'b0;
                    out_resv    <= 1'b0;
                    out_insn    <= {hi, in_data};
                end else begin
                    out_major   <= fld.major;
                    out_minor   <= fld.minor;
                    out_illegal <= fld.all0;
                    out_nop     <= fld.nop_m | ((mode_q == MD_C16) & fld.nop_n);
                    out_resv    <= (mode_q == MD_C16) & fld.resv;
                    out_insn    <= {{PARCEL_W{1'b0}}, in_data};
                end
            end
        end
    end

    // R11: flush silences the next cycle and sets the requested mode
    p_flush_sets_mode_r11: assert property (@(posedge clk) disable iff (rst)
        flush |=> (!out_valid && out_mode == ($past(flush_mode) ? MD_C16 : MD_STD)));

    // R5: an immediate-form result always leaves the sequencer in sixteen-bit mode
    p_imm_keeps_c16_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == FC_C16IMM) |-> out_mode == MD_C16);

    // R7: completing a 32-bit word never leaves a pending one-shot
    p_pair_ends_oneshot_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_class == FC_STD32) |-> out_mode != MD_ONE);

    // R8: illegal only on a zero compressed parcel
    p_illegal_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_insn == '0 && out_class != FC_STD32));

    // R4: a parcel accepted in sixteen-bit mode always yields a sixteen-bit class
    p_c16_emits_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && out_mode == MD_C16)
        |=> (out_valid && (out_class == FC_C16 || out_class == FC_C16IMM)));

    // R2: the first half of a 32-bit word produces no output
    p_first_half_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !flush && out_mode != MD_C16 && !pend
         && in_data[PARCEL_W-1 -: PFX_W] != '0) |=> !out_valid);

    // R10: the reserved flag appears only on sixteen-bit results
    p_resv_c16_only_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_resv) |-> out_class == FC_C16);
endmodule

// File: tb/cparcel_seq_tb_top.sv
module cparcel_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, flush, flush_mode;
    logic [15:0] in_data;
    logic        in_ready, out_valid, out_minor, out_illegal, out_nop, out_resv;
    logic [1:0]  out_class, out_mode;
    logic [2:0]  out_major;
    logic [31:0] out_insn;

    always #5 clk = ~clk;

    cparcel_seq dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .flush(flush), .flush_mode(flush_mode),
        .out_valid(out_valid), .out_class(out_class), .out_major(out_major),
        .out_minor(out_minor), .out_illegal(out_illegal), .out_nop(out_nop),
        .out_resv(out_resv), .out_insn(out_insn), .out_mode(out_mode)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state: 0 standard, 1 sixteen-bit, 2 one-shot
    int          m_mode = 0;
    bit          m_hv   = 0;
    logic [15:0] m_hi   = '0;
    bit          e_v;
    int          e_cls, e_maj, e_min, e_ill, e_nop, e_resv;
    logic [31:0] e_insn;
    string       e_tag;

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model(bit v, logic [15:0] d, bit fl, bit fm);
        e_v = 0; e_tag = "R12";
        if (fl) begin
            m_hv = 0; m_mode = fm ? 1 : 0; e_tag = "R11";
            return;
        end
        if (!v) return;
        e_maj = (d >> 8) & 7; e_min = (d >> 7) & 1;
        e_ill = (d == 0); e_nop = (d == 16'h0001); e_resv = 0;
        e_insn = {16'h0, d};
        if (m_mode != 1) begin
            if (m_hv) begin
                e_v = 1; e_cls = 0; e_maj = 0; e_min = 0; e_ill = 0; e_nop = 0;
                e_insn = {m_hi, d}; m_hv = 0;
                e_tag = (m_mode == 2) ? "R7" : "R2";
                m_mode = (m_mode == 2) ? 1 : 0;
            end else if ((d >> 11) == 0) begin
                e_v = 1; e_cls = 1;
                e_tag = (m_mode == 2) ? "R7" : (e_ill ? "R8" : (e_nop ? "R9" : "R3"));
                m_mode = d[0] ? 1 : 0;
            end else begin
                m_hv = 1; m_hi = d; e_tag = "R2";
            end
        end else begin
            e_v = 1; e_cls = 2; e_tag = "R4";
            e_nop = (d == 16'h0001) || (d == 16'h8000);
            e_resv = d[15] && (d[14:11] != 0) && (d[10:0] == 0);
            if (e_maj == 1 && e_min == 1) begin
                m_mode = d[0] ? 1 : 0; e_tag = "R6";
            end else if (!d[15] && d[0]) m_mode = 1;
            else if (!d[15] && !d[0]) m_mode = 0;
            else if (d[15] && !d[0]) m_mode = 2;
            else begin e_cls = 3; m_mode = 1; e_tag = "R5"; end
            if (e_ill) e_tag = "R8";
            else if (e_nop) e_tag = "R9";
            else if (e_resv) e_tag = "R10";
        end
    endtask

    task automatic step(bit v, logic [15:0] d, bit fl, bit fm);
        in_valid = v; in_data = d; flush = fl; flush_mode = fm;
        #1;
        chk("R11", "in_ready", in_ready, !fl);
        @(posedge clk);
        model(v, d, fl, fm);
        @(negedge clk);
        chk(e_tag, "out_valid", out_valid, e_v);
        chk(e_tag, "out_mode", out_mode, m_mode);
        if (e_v && out_valid) begin
            chk(e_tag, "class", out_class, e_cls);
            chk(e_tag, "major", out_major, e_maj);
            chk(e_tag, "minor", out_minor, e_min);
            chk(e_tag, "illegal", out_illegal, e_ill);
            chk(e_tag, "nop", out_nop, e_nop);
            chk(e_tag, "resv", out_resv, e_resv);
            chk(e_tag, "insn", out_insn, e_insn);
        end
    endtask

    task automatic put(logic [15:0] d);
        step(1, d, 0, 0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        rst = 1; in_valid = 0; in_data = '0; flush = 0; flush_mode = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset out_mode", out_mode, 0);

        put(16'h7C00); put(16'h1234);              // R2 back-to-back pair
        step(0, 16'h0, 0, 0);
        put(16'h4801); step(0, 16'h0, 0, 0); step(0, 16'h0, 0, 0); put(16'hBEEF); // R2 gapped
        put(16'h0300);                              // R3 10-bit, M=0
        put(16'h0000);                              // R8 illegal, 10-bit
        put(16'h0001);                              // R9 nop -> sixteen-bit
        put(16'h0201);                              // R4 stay
        put(16'h8501);                              // R5 immediate
        put(16'h8180);                              // R6 sub-opcode, M=0 -> standard
        put(16'h05F1);                              // R3 M=1 -> sixteen-bit
        put(16'h8000);                              // R9 nop -> one-shot
        put(16'h4800); put(16'h0010);               // R7 pair returns to sixteen-bit
        put(16'h0000);                              // R8 illegal in sixteen-bit -> standard
        put(16'h0001);
        put(16'h9000);                              // R10 reserved -> one-shot
        put(16'h0001);                              // R7 10-bit in one-shot, M=1
        put(16'h0680);                              // R4 N,M=0,0 -> standard
        put(16'h0001);
        put(16'h8000);                              // one-shot
        put(16'h6000);                              // first half held
        step(1, 16'h1111, 1, 0);                    // R11 flush beats pending return
        put(16'h0101);                              // decodes as 10-bit in standard
        put(16'h6000);
        step(1, 16'h2222, 1, 1);                    // R11 flush to sixteen-bit
        put(16'h8181);                              // R6 N ignored, stays
        put(16'h0180);                              // R6 M=0 -> standard

        for (int i = 0; i < 2000; i++) begin
            logic [15:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (lfsr[2:0])
                3'd0: d = 16'h0000;
                3'd1: d = 16'h0001;
                3'd2: d = 16'h8000;
                3'd3: d = {5'b0, lfsr[15:5]};
                default: d = {lfsr[7:0], lfsr[15:8]};
            endcase
            step(lfsr[9] | lfsr[4], d, lfsr[15:11] == 5'd0, lfsr[6]);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule